// File: doc/BRIEF.md
# Translation Cache with Access Rights

This block is a small fully associative cache of address translations. A requester presents a 32-bit virtual address with an access kind (read, write or instruction fetch). In the same cycle the block compares the virtual page number against every stored tag at once. On a match it returns the physical address, which is the stored physical page number joined to the untranslated 12-bit page offset. It also compares the entry's rights with the access kind and reports either a permitted access or a protection fault. When nothing matches, the block raises a refill request.

An external page-table walker answers that request with a fill write: the page number, the frame number and three rights bits. The block places the fill in a free entry when one exists, and otherwise in the entry named by a rotating pointer. Each entry keeps a modified flag that a permitted write sets. When a fill replaces an entry whose flag is set, the block reports that entry's page and frame on the same cycle, so the walker can mark the page as modified in memory. A flush input invalidates every entry at once.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no entry is valid. Every lookup misses with `refill_req` high and `paddr` zero, and the first fills raise no eviction.
- R2: A lookup whose page number matches a valid entry raises `hit` in the same cycle, with `paddr` equal to {stored frame number, address bits 11:0}.
- R3: An entry that is not valid never matches, whatever its tag. After a page has been replaced, a lookup of its old page number misses.
- R4: While `lk_valid` is high, exactly one of `hit` and `refill_req` is high. While `lk_valid` is low, `hit`, `refill_req`, `pa_ok` and `prot_fault` are all low. `paddr` is zero whenever `hit` is low.
- R5: The access kind `lk_acc` is encoded 2'b00 read, 2'b01 write, 2'b10 fetch and 2'b11 read. On a hit, `pa_ok` is high and `prot_fault` is low when the entry's matching right (r, w or x) is set. Otherwise `prot_fault` is high and `pa_ok` is low.
- R6: A permitted write hit sets that entry's modified flag.
- R7: A read hit, a fetch hit and a faulting write hit leave the modified flag unchanged.
- R8: A fill whose page is absent goes to the lowest-numbered invalid entry when one exists. Placing a fill in an invalid entry never raises an eviction.
- R9: When every entry is valid, the fill replaces the entry named by a rotating pointer. The pointer is 0 after reset, advances by one (wrapping at ENTRIES) on every fill that is taken, and is not changed by a flush.
- R10: A fill whose page number is already present overwrites that entry's frame and rights in place. It keeps that entry's modified flag, raises no eviction and creates no second copy.
- R11: When a fill replaces a valid entry whose modified flag is set, `evict_valid` is high during the fill cycle, with that entry's page number on `evict_vpn` and its frame number on `evict_ppn`. A clean victim raises nothing.
- R12: `flush` invalidates all entries in one cycle, and a fill presented in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| hit | output | 1 | A valid entry matches the page number |
| paddr | output | 32 | Translated physical address (zero when no hit) |
| pa_ok | output | 1 | Hit and access permitted |
| prot_fault | output | 1 | Hit but the rights forbid the access |
| refill_req | output | 1 | Lookup missed; a walker fill is wanted |
| fill_en | input | 1 | Fill write from the walker |
| fill_vpn | input | 20 | Page number of the fill |
| fill_ppn | input | 20 | Frame number of the fill |
| fill_r | input | 1 | Read right of the fill |
| fill_w | input | 1 | Write right of the fill |
| fill_x | input | 1 | Fetch right of the fill |
| flush | input | 1 | Invalidate all entries |
| evict_valid | output | 1 | A modified entry is being replaced this cycle |
| evict_vpn | output | 20 | Page number of the replaced modified entry |
| evict_ppn | output | 20 | Frame number of the replaced modified entry |

## Verification
Every cycle, the assertions check that a lookup produces a hit or a refill request but never both, and that a hit always splits into either a permitted access or a fault. They also check that no page number ever matches two entries, that an eviction appears only with an accepted fill of an absent page, and that after a flush no lookup hits. Which entry a fill chooses, the order of the rotating pointer, whether the modified flag was set by the right accesses, and whether the flag survives an in-place overwrite are only visible through the eviction reports. The bench's fill sequences bring these out by filling, writing and replacing every entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_EX  = 2'b10,
        ACC_RD2 = 2'b11
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
    parameter int N     = 32,
    parameter int W     = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N*W-1:0]   tags_flat,
    input  logic [N-1:0]     vld,
    input  logic [W-1:0]     key,
    output logic [N-1:0]     match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags_flat[g*W +: W] == key);
    end

    assign any = |match;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N     = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vld,
    input  logic [IDX_W-1:0] rr,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = rr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int OFS_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + OFS_W,
    localparam int PA_W   = PPN_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    output logic             hit,
    output logic [PA_W-1:0]  paddr,
    output logic             pa_ok,
    output logic             prot_fault,
    output logic             refill_req,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_r,
    input  logic             fill_w,
    input  logic             fill_x,
    input  logic             flush,
    output logic             evict_valid,
    output logic [VPN_W-1:0] evict_vpn,
    output logic [PPN_W-1:0] evict_ppn
);

    typedef struct packed {
        logic             vld;
        logic             dirty;
        perm_t            perm;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]   rr;
    } st_t;

    st_t st_d, st_q;

    logic [ENTRIES*VPN_W-1:0] tags_flat;
    logic [ENTRIES-1:0]       vld_vec;
    logic [ENTRIES-1:0]       lk_match, f_match;
    logic                     lk_any, f_any;
    logic [IDX_W-1:0]         lk_idx, f_idx, vic_idx, tgt_idx;
    logic [VPN_W-1:0]         lk_vpn;
    logic [OFS_W-1:0]         lk_ofs;
    ent_t                     hit_ent, vic_ent;
    logic                     allowed;
    logic                     take_fill;

    assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];
    assign lk_ofs = lk_vaddr[OFS_W-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign tags_flat[g*VPN_W +: VPN_W] = st_q.ent[g].tag;
        assign vld_vec[g]                  = st_q.ent[g].vld;
    end

    xlat_cam #(.N(ENTRIES), .W(VPN_W)) u_look (
        .tags_flat (tags_flat),
        .vld       (vld_vec),
        .key       (lk_vpn),
        .match     (lk_match),
        .any       (lk_any),
        .idx       (lk_idx)
    );

    xlat_cam #(.N(ENTRIES), .W(VPN_W)) u_fmatch (
        .tags_flat (tags_flat),
        .vld       (vld_vec),
        .key       (fill_vpn),
        .match     (f_match),
        .any       (f_any),
        .idx       (f_idx)
    );

    xlat_victim #(.N(ENTRIES)) u_vic (
        .vld (vld_vec),
        .rr  (st_q.rr),
        .idx (vic_idx)
    );

    // Lookup side: hit, rights check and translated address
    always_comb begin
        hit_ent = st_q.ent[lk_idx];
        unique case (acc_e'(lk_acc))
            ACC_WR:  allowed = hit_ent.perm.w;
            ACC_EX:  allowed = hit_ent.perm.x;
            default: allowed = hit_ent.perm.r;
        endcase
        hit        = lk_valid && lk_any;
        refill_req = lk_valid && !lk_any;
        pa_ok      = hit && allowed;
        prot_fault = hit && !allowed;
        paddr      = hit ? {hit_ent.ppn, lk_ofs} : '0;
    end

    // Fill side: target choice and eviction report
    always_comb begin
        take_fill   = fill_en && !flush;
        tgt_idx     = f_any ? f_idx : vic_idx;
        vic_ent     = st_q.ent[vic_idx];
        evict_valid = take_fill && !f_any && vic_ent.vld && vic_ent.dirty;
        evict_vpn   = evict_valid ? vic_ent.tag : '0;
        evict_ppn   = evict_valid ? vic_ent.ppn : '0;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (pa_ok && acc_e'(lk_acc) == ACC_WR) begin
            st_d.ent[lk_idx].dirty = 1'b1;
        end
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ent[i].vld = 1'b0;
            end
        end else if (fill_en) begin
            st_d.ent[tgt_idx].dirty = f_any ? st_d.ent[tgt_idx].dirty : 1'b0;
            st_d.ent[tgt_idx].vld   = 1'b1;
            st_d.ent[tgt_idx].tag   = fill_vpn;
            st_d.ent[tgt_idx].ppn   = fill_ppn;
            st_d.ent[tgt_idx].perm  = '{x: fill_x, w: fill_w, r: fill_r};
            st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               hit,
    input logic               refill_req,
    input logic               pa_ok,
    input logic               prot_fault,
    input logic               flush,
    input logic               fill_en,
    input logic               evict_valid,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] f_match
);

    AST_HIT_OR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (hit ^ refill_req)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!hit && !refill_req && !pa_ok && !prot_fault)); // R4

    AST_RIGHTS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa_ok ^ prot_fault)); // R5

    AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(f_match)); // R10

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit); // R12

    AST_EVICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (fill_en && !flush && f_match == '0)); // R11

endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .hit         (hit),
    .refill_req  (refill_req),
    .pa_ok       (pa_ok),
    .prot_fault  (prot_fault),
    .flush       (flush),
    .fill_en     (fill_en),
    .evict_valid (evict_valid),
    .lk_match    (lk_match),
    .f_match     (f_match)
);

// File: tb/sim_xlat_tlb.sv
module sim_xlat_tlb;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        hit, pa_ok, prot_fault, refill_req;
    logic [31:0] paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        fill_r = 1'b0, fill_w = 1'b0, fill_x = 1'b0;
    logic        flush = 1'b0;
    logic        evict_valid;
    logic [19:0] evict_vpn, evict_ppn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlat_tlb u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_acc(lk_acc), .hit(hit), .paddr(paddr), .pa_ok(pa_ok),
        .prot_fault(prot_fault), .refill_req(refill_req), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_r(fill_r),
        .fill_w(fill_w), .fill_x(fill_x), .flush(flush),
        .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_ppn(evict_ppn)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        lk_valid = 1'b0; fill_en = 1'b0; flush = 1'b0;
    endtask

    task automatic look(input logic [19:0] v, input logic [11:0] o, input logic [1:0] a);
        @(posedge clk); #1;
        fill_en = 1'b0; flush = 1'b0;
        lk_valid = 1'b1; lk_vaddr = {v, o}; lk_acc = a;
        @(negedge clk);
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [2:0] xwr,
                        input logic fl);
        @(posedge clk); #1;
        lk_valid = 1'b0;
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p;
        fill_r = xwr[0]; fill_w = xwr[1]; fill_x = xwr[2]; flush = fl;
        @(negedge clk);
    endtask

    function automatic logic right_of(input logic [2:0] xwr, input logic [1:0] a);
        if (a == 2'b01) return xwr[1];
        if (a == 2'b10) return xwr[2];
        return xwr[0];
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        look(20'h12345, 12'h0ab, 2'b00);
        chk("R1 hit", hit, 0);
        chk("R1 refill_req", refill_req, 1);
        chk("R1 paddr", paddr, 0);
        chk("R4 pa_ok on miss", pa_ok, 0);

        // Fill 32 entries; rights = index mod 8 as {x,w,r}
        for (int i = 0; i < N; i++) begin
            fill(20'(32'h100 + i), 20'(32'h800 + 3 * i), 3'(i % 8), 1'b0);
            chk("R1 R8 no evict into empty", evict_valid, 0);
        end
        idle();
        chk("R4 idle refill_req", refill_req, 0);

        // R2 R5 R6 R7: every entry, every access kind
        for (int i = 0; i < N; i++) begin
            for (int a = 0; a < 4; a++) begin
                logic ok;
                ok = right_of(3'(i % 8), 2'(a));
                look(20'(32'h100 + i), 12'(37 * i + a), 2'(a));
                chk("R2 hit", hit, 1);
                chk("R2 paddr", paddr, {20'(32'h800 + 3 * i), 12'(37 * i + a)});
                chk("R5 pa_ok", pa_ok, ok);
                chk("R5 prot_fault", prot_fault, !ok);
                chk("R4 no refill on hit", refill_req, 0);
            end
        end

        // R11 R6 R7 R9: pointer at 0, replace entries 0..31 in order
        for (int k = 0; k < N; k++) begin
            logic dirty_exp;
            dirty_exp = ((k % 8) & 2) != 0;
            fill(20'(32'h900 + k), 20'(32'h400 + k), 3'b111, 1'b0);
            chk("R11 R6 R7 evict_valid", evict_valid, dirty_exp);
            chk("R11 evict_vpn", evict_vpn, dirty_exp ? 20'(32'h100 + k) : 20'h0);
            chk("R11 evict_ppn", evict_ppn, dirty_exp ? 20'(32'h800 + 3 * k) : 20'h0);
        end
        look(20'h105, 12'h0, 2'b00);
        chk("R3 replaced page misses", hit, 0);
        look(20'h90a, 12'h123, 2'b10);
        chk("R2 new page paddr", paddr, {20'h40a, 12'h123});

        // R12: flush with a fill in the same cycle
        fill(20'h777, 20'h333, 3'b111, 1'b1);
        chk("R12 no evict on flush", evict_valid, 0);
        for (int k = 0; k < N; k += 7) begin
            look(20'(32'h900 + k), 12'h0, 2'b00);
            chk("R12 R3 flushed miss", hit, 0);
        end
        look(20'h777, 12'h0, 2'b00);
        chk("R12 dropped fill", hit, 0);

        // R8: refill an empty array, pointer is back at 0
        for (int j = 0; j < N; j++) begin
            fill(20'(32'ha00 + j), 20'(32'hb00 + j), 3'b011, 1'b0);
            chk("R8 no evict", evict_valid, 0);
        end
        for (int j = 0; j < N; j++) begin
            look(20'(32'ha00 + j), 12'h0, 2'b01);
            chk("R6 write ok", pa_ok, 1);
        end
        // R10: overwrite present page, pointer moves to 1
        fill(20'ha05, 20'hc55, 3'b011, 1'b0);
        chk("R10 no evict on overwrite", evict_valid, 0);
        look(20'ha05, 12'h777, 2'b00);
        chk("R10 new frame", paddr, {20'hc55, 12'h777});

        // R9 R8 R10 R11: victims follow the pointer from 1, wrapping
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (1 + k) % N;
            fill(20'(32'hd00 + k), 20'(32'he00 + k), 3'b001, 1'b0);
            chk("R9 R11 evict_valid", evict_valid, 1);
            chk("R9 R8 evict_vpn", evict_vpn, 20'(32'ha00 + idx));
            chk("R10 R11 evict_ppn", evict_ppn, (idx == 5) ? 20'hc55 : 20'(32'hb00 + idx));
        end
        idle();

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule